// File: doc/BRIEF.md
# Dual-Issue Operand Bypass Selector

This combinational unit sits beside the decode stage of a two-wide, in-order DSP pipeline. For the oldest instruction in decode it decides, for each of its two source operands (A and B), whether the value comes from the register file or from one of six in-flight results. Those results belong to the two issue slots of execute stages IX1, IX2 and IX3. The registers are 16 bits wide. A 32-bit "wide" operand or result occupies an even register together with the odd register just above it.

Each operand gets two 3-bit select codes: one for its low half (the named register) and one for its high half (the odd neighbour, used only by wide operands). Each operand also gets a flag saying that the value it depends on cannot be bypassed. Stall generation and the data multiplexers are built elsewhere from these outputs.

Producer index k is stage*2 + slot, with IX1 = stage 0 and slot 1 younger than slot 0. The select code for producer k is k + 1. Code 0 means the register file.

Top module: `bypass_sel_unit`

## Requirements
- R1: When decode is not valid, every select output is 0 and both no-forward flags are 0.
- R2: A producer matches a half when its destination id equals that half's register id. A wide producer also matches the odd id formed by forcing bit 0 of its destination to 1. A wide operand's high half uses its source id with bit 0 forced to 1.
- R3: A match counts only if decode is valid, the operand's read-enable is 1, and the producer's valid and write-enable bits are both 1.
- R4: When several producers match a half, the youngest wins. The order is IX1 before IX2 before IX3, and slot 1 before slot 0 within a stage.
- R5: The select code of a forwarded half is stage*2 + slot + 1, giving codes 1 to 6. A half with no match selects code 0.
- R6: If a winning producer does not have its forward-enable bit set, the operand's no-forward flag is 1.
- R7: A two-cycle producer that wins while in IX1 (codes 1 and 2) raises the no-forward flag. In IX2 or IX3 it forwards normally.
- R8: If a winning producer's wide flag differs from the operand's wide flag, the no-forward flag is 1.
- R9: A wide operand forwards only when both halves are won by the same producer. If the halves come from two producers, or one half has no match, the operand is flagged. A narrow operand always has a high-half select of 0.
- R10: Whenever an operand's no-forward flag is 1, both of its select codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_valid_i | input | 1 | Decode-stage instruction is valid |
| dec_src_a_i | input | 4 | Source register id of operand A |
| dec_src_b_i | input | 4 | Source register id of operand B |
| dec_rden_a_i | input | 1 | Operand A is read |
| dec_rden_b_i | input | 1 | Operand B is read |
| dec_wide_a_i | input | 1 | Operand A is a 32-bit register pair |
| dec_wide_b_i | input | 1 | Operand B is a 32-bit register pair |
| prod_valid_i | input | 6 | Valid bit per producer k |
| prod_wen_i | input | 6 | Write-enable per producer k |
| prod_dst_i | input | 24 | Destination id of producer k in bits [4k+3:4k] |
| prod_wide_i | input | 6 | Producer k writes a 32-bit pair |
| prod_fwd_ok_i | input | 6 | Producer k may be a bypass source |
| prod_two_cyc_i | input | 6 | Producer k is a two-cycle instruction |
| sel_a_lo_o | output | 3 | Source code for operand A low half |
| sel_a_hi_o | output | 3 | Source code for operand A high half |
| sel_b_lo_o | output | 3 | Source code for operand B low half |
| sel_b_hi_o | output | 3 | Source code for operand B high half |
| nofwd_a_o | output | 1 | Operand A depends on a result that cannot be bypassed |
| nofwd_b_o | output | 1 | Operand B depends on a result that cannot be bypassed |

## Verification
The hardest case to reach from the ports is a wide operand where a younger narrow producer overwrites just one half of a pair that an older wide producer wrote. Reaching it needs two live producers with adjacent ids in the right age order. The random sweep confines register ids to 0..7 and forces wide ids to be even, so such overlaps happen often. Directed cases also place a narrow writer of the odd register ahead of a wide writer of the pair. Every vector is compared against an arithmetic model of the match, priority and flag rules.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  localparam int unsigned DEF_REG_W    = 4;
  localparam int unsigned DEF_N_STAGES = 3;
  localparam int unsigned DEF_N_SLOTS  = 2;

  // Select code of producer (stage, slot); 0 is reserved for the register file.
  function automatic int unsigned prod_code(int unsigned stage, int unsigned slot,
                                            int unsigned n_slots);
    return stage * n_slots + slot + 1;
  endfunction
endpackage

// File: rtl/bypass_half_match.sv
module bypass_half_match #(
  parameter int unsigned REG_W  = 4,
  parameter int unsigned N_PROD = 6
) (
  input  logic                    need_i,
  input  logic [REG_W-1:0]        id_i,
  input  logic [N_PROD-1:0]       prod_live_i,
  input  logic [N_PROD*REG_W-1:0] prod_dst_i,
  input  logic [N_PROD-1:0]       prod_wide_i,
  output logic [N_PROD-1:0]       hit_o
);
  for (genvar k = 0; k < N_PROD; k++) begin : g_prod
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] dst_odd;
    assign dst     = prod_dst_i[k*REG_W +: REG_W];
    assign dst_odd = dst | REG_W'(1);
    assign hit_o[k] = need_i && prod_live_i[k] &&
                      ((dst == id_i) || (prod_wide_i[k] && (dst_odd == id_i)));
  end
endmodule

// File: rtl/bypass_youngest.sv
module bypass_youngest #(
  parameter int unsigned N_STAGES = 3,
  parameter int unsigned N_SLOTS  = 2,
  parameter int unsigned SEL_W    = 3
) (
  input  logic [N_STAGES*N_SLOTS-1:0] hit_i,
  output logic                        found_o,
  output logic [SEL_W-1:0]            code_o
);
  import bypass_pkg::*;

  // Walk oldest to youngest; the last hit written wins.
  always_comb begin
    found_o = 1'b0;
    code_o  = '0;
    for (int st = N_STAGES - 1; st >= 0; st--) begin
      for (int sl = 0; sl < N_SLOTS; sl++) begin
        if (hit_i[st*N_SLOTS + sl]) begin
          found_o = 1'b1;
          code_o  = SEL_W'(prod_code(st, sl, N_SLOTS));
        end
      end
    end
  end
endmodule

// File: rtl/bypass_operand.sv
module bypass_operand #(
  parameter int unsigned REG_W    = 4,
  parameter int unsigned N_STAGES = 3,
  parameter int unsigned N_SLOTS  = 2,
  localparam int unsigned N_PROD  = N_STAGES * N_SLOTS,
  localparam int unsigned SEL_W   = $clog2(N_PROD + 1)
) (
  input  logic                    dec_valid_i,
  input  logic [REG_W-1:0]        src_i,
  input  logic                    rden_i,
  input  logic                    wide_i,
  input  logic [N_PROD-1:0]       prod_live_i,
  input  logic [N_PROD*REG_W-1:0] prod_dst_i,
  input  logic [N_PROD-1:0]       prod_wide_i,
  input  logic [N_PROD-1:0]       prod_fwd_ok_i,
  input  logic [N_PROD-1:0]       prod_two_cyc_i,
  output logic [SEL_W-1:0]        sel_lo_o,
  output logic [SEL_W-1:0]        sel_hi_o,
  output logic                    nofwd_o
);
  localparam int unsigned IDX_W = (N_PROD > 1) ? $clog2(N_PROD) : 1;

  logic [1:0]       need;
  logic [REG_W-1:0] half_id [2];
  logic [1:0]       found;
  logic [SEL_W-1:0] code    [2];
  logic [1:0]       bad;
  logic             split;

  assign need[0]    = dec_valid_i && rden_i;
  assign need[1]    = need[0] && wide_i;
  assign half_id[0] = src_i;
  assign half_id[1] = src_i | REG_W'(1);

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [N_PROD-1:0] hit;
    logic [IDX_W-1:0]  idx;
    logic              early;

    bypass_half_match #(.REG_W(REG_W), .N_PROD(N_PROD)) match_i (
      .need_i      (need[h]),
      .id_i        (half_id[h]),
      .prod_live_i (prod_live_i),
      .prod_dst_i  (prod_dst_i),
      .prod_wide_i (prod_wide_i),
      .hit_o       (hit)
    );

    bypass_youngest #(.N_STAGES(N_STAGES), .N_SLOTS(N_SLOTS), .SEL_W(SEL_W)) pick_i (
      .hit_i   (hit),
      .found_o (found[h]),
      .code_o  (code[h])
    );

    assign idx   = found[h] ? IDX_W'(code[h] - SEL_W'(1)) : '0;
    // IX1 holds producer indices below N_SLOTS.
    assign early = prod_two_cyc_i[idx] && (idx < IDX_W'(N_SLOTS));
    assign bad[h] = found[h] &&
                    (!prod_fwd_ok_i[idx] || early || (prod_wide_i[idx] != wide_i));
  end

  assign split    = wide_i && ((found[0] != found[1]) || (code[0] != code[1]));
  assign nofwd_o  = |bad || split;
  assign sel_lo_o = nofwd_o ? '0 : code[0];
  assign sel_hi_o = (nofwd_o || !wide_i) ? '0 : code[1];
endmodule

// File: rtl/bypass_sel_unit.sv
module bypass_sel_unit #(
  parameter int unsigned REG_W    = bypass_pkg::DEF_REG_W,
  parameter int unsigned N_STAGES = bypass_pkg::DEF_N_STAGES,
  parameter int unsigned N_SLOTS  = bypass_pkg::DEF_N_SLOTS,
  localparam int unsigned N_PROD  = N_STAGES * N_SLOTS,
  localparam int unsigned SEL_W   = $clog2(N_PROD + 1)
) (
  input  logic                    dec_valid_i,
  input  logic [REG_W-1:0]        dec_src_a_i,
  input  logic [REG_W-1:0]        dec_src_b_i,
  input  logic                    dec_rden_a_i,
  input  logic                    dec_rden_b_i,
  input  logic                    dec_wide_a_i,
  input  logic                    dec_wide_b_i,
  input  logic [N_PROD-1:0]       prod_valid_i,
  input  logic [N_PROD-1:0]       prod_wen_i,
  input  logic [N_PROD*REG_W-1:0] prod_dst_i,
  input  logic [N_PROD-1:0]       prod_wide_i,
  input  logic [N_PROD-1:0]       prod_fwd_ok_i,
  input  logic [N_PROD-1:0]       prod_two_cyc_i,
  output logic [SEL_W-1:0]        sel_a_lo_o,
  output logic [SEL_W-1:0]        sel_a_hi_o,
  output logic [SEL_W-1:0]        sel_b_lo_o,
  output logic [SEL_W-1:0]        sel_b_hi_o,
  output logic                    nofwd_a_o,
  output logic                    nofwd_b_o
);
  logic [N_PROD-1:0] prod_live;
  assign prod_live = prod_valid_i & prod_wen_i;

  bypass_operand #(.REG_W(REG_W), .N_STAGES(N_STAGES), .N_SLOTS(N_SLOTS)) op_a_i (
    .dec_valid_i    (dec_valid_i),
    .src_i          (dec_src_a_i),
    .rden_i         (dec_rden_a_i),
    .wide_i         (dec_wide_a_i),
    .prod_live_i    (prod_live),
    .prod_dst_i     (prod_dst_i),
    .prod_wide_i    (prod_wide_i),
    .prod_fwd_ok_i  (prod_fwd_ok_i),
    .prod_two_cyc_i (prod_two_cyc_i),
    .sel_lo_o       (sel_a_lo_o),
    .sel_hi_o       (sel_a_hi_o),
    .nofwd_o        (nofwd_a_o)
  );

  bypass_operand #(.REG_W(REG_W), .N_STAGES(N_STAGES), .N_SLOTS(N_SLOTS)) op_b_i (
    .dec_valid_i    (dec_valid_i),
    .src_i          (dec_src_b_i),
    .rden_i         (dec_rden_b_i),
    .wide_i         (dec_wide_b_i),
    .prod_live_i    (prod_live),
    .prod_dst_i     (prod_dst_i),
    .prod_wide_i    (prod_wide_i),
    .prod_fwd_ok_i  (prod_fwd_ok_i),
    .prod_two_cyc_i (prod_two_cyc_i),
    .sel_lo_o       (sel_b_lo_o),
    .sel_hi_o       (sel_b_hi_o),
    .nofwd_o        (nofwd_b_o)
  );
endmodule

// File: rtl/bypass_sel_chk.sv
module bypass_sel_chk #(
  parameter int unsigned REG_W    = 4,
  parameter int unsigned N_STAGES = 3,
  parameter int unsigned N_SLOTS  = 2,
  localparam int unsigned N_PROD  = N_STAGES * N_SLOTS,
  localparam int unsigned SEL_W   = $clog2(N_PROD + 1)
) (
  input logic                    dec_valid_i,
  input logic                    dec_rden_a_i,
  input logic                    dec_rden_b_i,
  input logic                    dec_wide_a_i,
  input logic                    dec_wide_b_i,
  input logic [N_PROD-1:0]       prod_two_cyc_i,
  input logic [SEL_W-1:0]        sel_a_lo_o,
  input logic [SEL_W-1:0]        sel_a_hi_o,
  input logic [SEL_W-1:0]        sel_b_lo_o,
  input logic [SEL_W-1:0]        sel_b_hi_o,
  input logic                    nofwd_a_o,
  input logic                    nofwd_b_o
);
  always_comb begin
    // R1
    idle_quiet_chk: assert (dec_valid_i || ({sel_a_lo_o, sel_a_hi_o, sel_b_lo_o, sel_b_hi_o,
                                             nofwd_a_o, nofwd_b_o} == '0))
      else $error("outputs active while decode invalid");
    // R3
    unread_quiet_chk: assert ((dec_rden_a_i || ({sel_a_lo_o, sel_a_hi_o, nofwd_a_o} == '0)) &&
                              (dec_rden_b_i || ({sel_b_lo_o, sel_b_hi_o, nofwd_b_o} == '0)))
      else $error("unread operand has a source");
    // R5
    code_range_chk: assert (sel_a_lo_o <= SEL_W'(N_PROD) && sel_a_hi_o <= SEL_W'(N_PROD) &&
                            sel_b_lo_o <= SEL_W'(N_PROD) && sel_b_hi_o <= SEL_W'(N_PROD))
      else $error("select code out of range");
    // R7
    early_src_chk: assert (!((sel_a_lo_o != '0) && (sel_a_lo_o <= SEL_W'(N_SLOTS)) &&
                             prod_two_cyc_i[sel_a_lo_o - SEL_W'(1)]) &&
                           !((sel_b_lo_o != '0) && (sel_b_lo_o <= SEL_W'(N_SLOTS)) &&
                             prod_two_cyc_i[sel_b_lo_o - SEL_W'(1)]))
      else $error("two-cycle producer forwarded from IX1");
    // R9
    pair_same_chk: assert ((dec_wide_a_i ? (sel_a_hi_o == sel_a_lo_o) : (sel_a_hi_o == '0)) &&
                           (dec_wide_b_i ? (sel_b_hi_o == sel_b_lo_o) : (sel_b_hi_o == '0)))
      else $error("halves disagree");
    // R10
    nofwd_zero_chk: assert ((!nofwd_a_o || ({sel_a_lo_o, sel_a_hi_o} == '0)) &&
                            (!nofwd_b_o || ({sel_b_lo_o, sel_b_hi_o} == '0)))
      else $error("select driven while flagged");
  end
endmodule

bind bypass_sel_unit bypass_sel_chk #(.REG_W(REG_W), .N_STAGES(N_STAGES), .N_SLOTS(N_SLOTS)) chk_i (
  .dec_valid_i    (dec_valid_i),
  .dec_rden_a_i   (dec_rden_a_i),
  .dec_rden_b_i   (dec_rden_b_i),
  .dec_wide_a_i   (dec_wide_a_i),
  .dec_wide_b_i   (dec_wide_b_i),
  .prod_two_cyc_i (prod_two_cyc_i),
  .sel_a_lo_o     (sel_a_lo_o),
  .sel_a_hi_o     (sel_a_hi_o),
  .sel_b_lo_o     (sel_b_lo_o),
  .sel_b_hi_o     (sel_b_hi_o),
  .nofwd_a_o      (nofwd_a_o),
  .nofwd_b_o      (nofwd_b_o)
);

// File: tb/bypass_sel_unit_tb_top.sv
module bypass_sel_unit_tb_top;
  localparam int NP = 6;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic          dv;
  logic [3:0]    sa, sb;
  logic          rea, reb, wa, wb;
  logic [NP-1:0] pv, pw, pl, pf, p2;
  logic [4*NP-1:0] prd;
  logic [2:0]    a_lo, a_hi, b_lo, b_hi;
  logic          nf_a, nf_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bypass_sel_unit dut_i (
    .dec_valid_i(dv), .dec_src_a_i(sa), .dec_src_b_i(sb),
    .dec_rden_a_i(rea), .dec_rden_b_i(reb), .dec_wide_a_i(wa), .dec_wide_b_i(wb),
    .prod_valid_i(pv), .prod_wen_i(pw), .prod_dst_i(prd), .prod_wide_i(pl),
    .prod_fwd_ok_i(pf), .prod_two_cyc_i(p2),
    .sel_a_lo_o(a_lo), .sel_a_hi_o(a_hi), .sel_b_lo_o(b_lo), .sel_b_hi_o(b_hi),
    .nofwd_a_o(nf_a), .nofwd_b_o(nf_b)
  );

  // Reference: {nofwd, hi, lo} from the written rules.
  function automatic logic [6:0] model_op(logic [3:0] src, logic re, logic lng);
    logic [2:0] code [2];
    logic       fnd  [2];
    logic       bad;
    logic [3:0] id, d;
    bad = 1'b0;
    for (int h = 0; h < 2; h++) begin
      code[h] = 3'd0;
      fnd[h]  = 1'b0;
      if (dv && re && (h == 0 || lng)) begin
        id = (h == 1) ? (src | 4'd1) : src;
        for (int st = 2; st >= 0; st--) begin
          for (int sl = 0; sl < 2; sl++) begin
            int k;
            k = st * 2 + sl;
            d = prd[k*4 +: 4];
            if (pv[k] && pw[k] && (d == id || (pl[k] && (d | 4'd1) == id))) begin
              fnd[h]  = 1'b1;
              code[h] = 3'(k + 1);
            end
          end
        end
      end
      if (fnd[h]) begin
        int k;
        k = int'(code[h]) - 1;
        if (!pf[k] || (p2[k] && k < 2) || (pl[k] != lng)) bad = 1'b1;
      end
    end
    if (lng && (fnd[0] != fnd[1] || code[0] != code[1])) bad = 1'b1;
    if (bad) return {1'b1, 3'd0, 3'd0};
    return {1'b0, lng ? code[1] : 3'd0, code[0]};
  endfunction

  task automatic check(string tag);
    logic [6:0] ea, eb;
    @(posedge clk);
    #1;
    ea = model_op(sa, rea, wa);
    eb = model_op(sb, reb, wb);
    checks++;
    if ({nf_a, a_hi, a_lo} != ea || {nf_b, b_hi, b_lo} != eb) begin
      fails++;
      $display("FAIL %s: A got nf=%0d hi=%0d lo=%0d exp nf=%0d hi=%0d lo=%0d | B got nf=%0d hi=%0d lo=%0d exp nf=%0d hi=%0d lo=%0d",
               tag, nf_a, a_hi, a_lo, ea[6], ea[5:3], ea[2:0],
               nf_b, b_hi, b_lo, eb[6], eb[5:3], eb[2:0]);
    end
  endtask

  task automatic expect_a(string tag, logic [2:0] lo, logic [2:0] hi, logic nf);
    checks++;
    if (a_lo != lo || a_hi != hi || nf_a != nf) begin
      fails++;
      $display("FAIL %s: A got lo=%0d hi=%0d nf=%0d exp lo=%0d hi=%0d nf=%0d",
               tag, a_lo, a_hi, nf_a, lo, hi, nf);
    end
  endtask

  task automatic clear();
    @(negedge clk);
    dv = 0; sa = 0; sb = 0; rea = 0; reb = 0; wa = 0; wb = 0;
    pv = 0; pw = 0; pl = 0; pf = 0; p2 = 0; prd = 0;
  endtask

  task automatic put(int k, logic [3:0] rd, logic lng, logic fwd, logic two);
    pv[k] = 1; pw[k] = 1; prd[k*4 +: 4] = rd; pl[k] = lng; pf[k] = fwd; p2[k] = two;
  endtask

  task automatic read_a(logic [3:0] s, logic lng);
    dv = 1; rea = 1; sa = s; wa = lng;
  endtask

  initial begin
    clear();
    check("R1 idle inputs");
    expect_a("R1 idle", 3'd0, 3'd0, 1'b0);

    // R1: live match but decode invalid
    clear(); put(0, 4'd5, 0, 1, 0); rea = 1; sa = 4'd5;
    check("R1 decode invalid"); expect_a("R1 decode invalid", 0, 0, 0);

    // R2 / R5: narrow match on IX2 slot 0 -> code 3
    clear(); read_a(4'd5, 0); put(2, 4'd5, 0, 1, 0);
    check("R2 narrow equal"); expect_a("R5 IX2 slot0", 3'd3, 3'd0, 1'b0);

    // R2 / R8: narrow source on odd half of wide producer
    clear(); read_a(4'd7, 0); put(4, 4'd6, 1, 1, 0);
    check("R2 odd of wide dst"); expect_a("R8 narrow vs wide", 0, 0, 1);

    // R2 / R8: wide source odd half hits narrow producer
    clear(); read_a(4'd4, 1); put(1, 4'd5, 0, 1, 0);
    check("R2 wide src odd"); expect_a("R9 one half only", 0, 0, 1);

    // R3: write-enable off, read-enable off, valid off
    clear(); read_a(4'd5, 0); put(0, 4'd5, 0, 1, 0); pw[0] = 0;
    check("R3 no write"); expect_a("R3 no write", 0, 0, 0);
    clear(); read_a(4'd5, 0); put(0, 4'd5, 0, 1, 0); rea = 0;
    check("R3 no read"); expect_a("R3 no read", 0, 0, 0);
    clear(); read_a(4'd5, 0); put(3, 4'd5, 0, 1, 0); pv[3] = 0;
    check("R3 producer invalid"); expect_a("R3 producer invalid", 0, 0, 0);

    // R4: youngest of several
    clear(); read_a(4'd9, 0); put(5, 4'd9, 0, 1, 0); put(2, 4'd9, 0, 1, 0); put(0, 4'd9, 0, 1, 0);
    check("R4 three stages"); expect_a("R4 IX1 slot0", 3'd1, 0, 0);
    put(1, 4'd9, 0, 1, 0);
    check("R4 slot order"); expect_a("R4 IX1 slot1", 3'd2, 0, 0);
    clear(); read_a(4'd9, 0); put(4, 4'd9, 0, 1, 0); put(5, 4'd9, 0, 1, 0);
    check("R4 IX3 pair"); expect_a("R4 IX3 slot1", 3'd6, 0, 0);

    // R5: each producer alone
    for (int k = 0; k < NP; k++) begin
      clear(); read_a(4'd3, 0); put(k, 4'd3, 0, 1, 0);
      check("R5 single producer"); expect_a("R5 code", 3'(k + 1), 0, 0);
    end

    // R6: youngest cannot forward, older could
    clear(); read_a(4'd2, 0); put(4, 4'd2, 0, 1, 0); put(1, 4'd2, 0, 0, 0);
    check("R6 non-forwarding winner"); expect_a("R6 nofwd", 0, 0, 1);

    // R7: two-cycle producer in IX1 vs IX2
    clear(); read_a(4'd6, 1); put(1, 4'd6, 1, 1, 1);
    check("R7 two-cycle IX1"); expect_a("R7 IX1", 0, 0, 1);
    clear(); read_a(4'd6, 1); put(3, 4'd6, 1, 1, 1);
    check("R7 two-cycle IX2"); expect_a("R7 IX2", 3'd4, 3'd4, 0);

    // R8: wide source, wide id match on narrow producer of even reg
    clear(); read_a(4'd8, 1); put(0, 4'd8, 0, 1, 0); put(2, 4'd9, 0, 1, 0);
    check("R8 two narrow halves"); expect_a("R9 two narrow", 0, 0, 1);

    // R9: wide from single wide producer; younger narrow on odd half
    clear(); read_a(4'd10, 1); put(5, 4'd10, 1, 1, 0);
    check("R9 wide pair"); expect_a("R9 pair", 3'd6, 3'd6, 0);
    put(2, 4'd11, 0, 1, 0);
    check("R9 split halves"); expect_a("R10 split zeroed", 0, 0, 1);

    // Operand B alongside A
    clear(); read_a(4'd1, 0); reb = 1; sb = 4'd12; wb = 1; put(1, 4'd12, 1, 1, 0); put(0, 4'd1, 0, 1, 0);
    check("R4 both operands");

    // Random sweep over a narrow id range
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      dv  = ($urandom_range(0, 7) != 0);
      rea = $urandom_range(0, 1); reb = $urandom_range(0, 1);
      wa  = $urandom_range(0, 1); wb  = $urandom_range(0, 1);
      sa  = 4'($urandom_range(0, 7)); sb = 4'($urandom_range(0, 7));
      if (wa) sa[0] = 1'b0;
      if (wb) sb[0] = 1'b0;
      pv = 6'($urandom); pw = 6'($urandom | $urandom); pl = 6'($urandom);
      pf = 6'($urandom | $urandom); p2 = 6'($urandom & $urandom);
      for (int k = 0; k < NP; k++) begin
        prd[k*4 +: 4] = 4'($urandom_range(0, 7));
        if (pl[k]) prd[k*4] = 1'b0;
      end
      check("R2 R4 R6 R7 R8 R9 random");
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule